// File: doc/BRIEF.md
# Conversion Sequencer for a 12-bit Converter

This block decides which analog channel an external 12-bit converter samples next, and it stores each finished sample. It holds a table of sixteen 4-bit channel-select slots and a bank of sixteen result words. Each result word is indexed by the slot that produced it. The slots can run as two independent sequencers of eight slots each: the low sequencer on slots 0–7 and the high sequencer on slots 8–15. They can also be joined into one sequencer that covers all sixteen slots.

A session is started by a software write, by one of two timer-event pulses or by an external pin. Each source has its own mask. A session runs a programmed number of conversions. In start/stop operation the pointer then stays where it finished, and the next trigger resumes from that slot. In continuous operation the sequencer restarts by itself. A per-sequencer reset returns the pointer to its first slot. The block raises an end-of-session interrupt pulse, either on every session or on every second session.

Configuration goes through a plain write port, and results are read through an index. Conversions are requested one at a time. The block pulses `convStart` with the channel and waits for `convDone` with the data. When both sequencers want the converter, the low sequencer wins.

Top module: `adc_autoseq`

## Requirements
- R1: Write addresses 4 to 7 load slot words 0 to 3. Slot 4k+j takes bits 4j+3:4j of word k. Each conversion requests the channel stored in the slot at the pointer.
- R2: A finished conversion is stored in the result whose index equals the slot that requested it. The 12-bit sample sits in bits 15:4 and bits 3:0 are zero. `rdData` shows the result selected by `rdIdx`.
- R3: Mode register (address 0) bit 0 selects the joined mode. In split mode the low sequencer walks slots 0–7 and the high one walks slots 8–15. The count register (address 3) holds the low count in bits 2:0 and the high count in bits 6:4. In joined mode one sequencer walks slots 0–15 with its count in bits 3:0. A session runs count+1 conversions, and the high sequencer never runs in joined mode.
- R4: With mode bit 1 clear, a session ends with the pointer on the slot after the last one converted. The pointer wraps from the sequencer's last slot to its first. The next trigger resumes from that slot.
- R5: With mode bit 1 set, the sequencer restarts after each session. With mode bit 2 clear the pointer goes back to the first slot at each session end. With mode bit 2 set it advances through the last slot before wrapping.
- R6: Writing a sequencer control word with bit 1 set moves its pointer to its first slot at once. The write stops the sequencer and discards its pending request. The bit is not stored.
- R7: Low control (address 1) has these bits: 0 = software start, 2 = mask for event A, 3 = mask for event B (honoured only in joined mode), 4 = mask for the external pin. High control (address 2) has bit 0 = software start (honoured only in split mode) and bit 3 = mask for event B. An unmasked source starts nothing.
- R8: Writing a control word with bit 0 clear cancels that sequencer's pending request.
- R9: A trigger that arrives while a sequencer is busy is kept as a single pending request, and a second session starts when the current one ends. Any further triggers in that window are dropped.
- R10: Only one conversion is outstanding at a time. When both sequencers are waiting, the low sequencer is served first.
- R11: In each control word, bit 5 enables the interrupt and bit 6 selects every-other mode. In every-other mode the pulse is raised only on the 2nd, 4th and later session ends after a reset.
- R12: After reset all results read zero, and `convStart`, `irqLo` and `irqHi` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdIdx | input | 4 | Result index to read |
| rdData | output | 16 | Selected result word |
| trigEvA | input | 1 | Timer event A start pulse |
| trigEvB | input | 1 | Timer event B start pulse |
| trigExt | input | 1 | External pin start pulse |
| convStart | output | 1 | One-cycle conversion request |
| convChan | output | 4 | Channel for the requested conversion |
| convDone | input | 1 | Converter finished, data valid |
| convData | input | 12 | Converter sample |
| irqLo | output | 1 | Low sequencer end-of-session pulse |
| irqHi | output | 1 | High sequencer end-of-session pulse |

## Verification
Some properties are checked by assertions on every cycle. There is never a second request while a conversion is outstanding, and the high sequencer is never granted the converter in joined mode. A pending request always implies a busy sequencer, a sequencer reset lands the pointer on the first slot, and interrupt pulses last exactly one cycle. Other behaviour can only be shown by the bench scenarios. These include the slot-to-channel order and the result justification, resuming mid-table between triggers, and both wrap points of continuous operation. They also include the mask and mode gating of each source, the single pending request, and the every-other interrupt count.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int SLOT_N = 16;
  localparam int CHAN_W = 4;
  localparam int CONV_W = 12;
  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(SLOT_N);
  localparam int HALF_N = SLOT_N / 2;
  localparam int SLOTS_PER_WORD = WORD_W / CHAN_W;
  localparam int WORD_SEL_W = $clog2(SLOT_N / SLOTS_PER_WORD);

  typedef struct packed {
    logic                  resWe;
    logic [IDX_W-1:0]      resIdx;
    logic [IDX_W-1:0]      lookIdx;
    logic                  slotWe;
    logic [WORD_SEL_W-1:0] slotWord;
  } dpStrobe_t;
endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [CONV_W-1:0] convData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CHAN_W-1:0] lookChan,
  output logic [WORD_W-1:0] rdData
);
  localparam int PAD_W = WORD_W - CONV_W;

  logic [CHAN_W-1:0] slotTab [SLOT_N];
  logic [WORD_W-1:0] resMem  [SLOT_N];

  for (genvar i = 0; i < SLOT_N; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotTab[i] <= '0;
        resMem[i]  <= '0;
      end else begin
        if (strobe.slotWe && int'(strobe.slotWord) == i / SLOTS_PER_WORD)
          slotTab[i] <= wrData[(i % SLOTS_PER_WORD) * CHAN_W +: CHAN_W];
        if (strobe.resWe && int'(strobe.resIdx) == i)
          resMem[i] <= {convData, {PAD_W{1'b0}}};
      end
    end
  end

  assign lookChan = slotTab[strobe.lookIdx];
  assign rdData   = resMem[rdIdx];
endmodule

// File: rtl/adcseq_track.sv
module adcseq_track
  import adcseq_pkg::*;
#(
  parameter int INIT_SLOT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] endSlot,
  input  logic [IDX_W-1:0] maxCnt,
  input  logic             contRun,
  input  logic             wrapAtEnd,
  input  logic             trig,
  input  logic             pendClear,
  input  logic             seqReset,
  input  logic             stepDone,
  input  logic             intEn,
  input  logic             intAlt,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             intPulse
);
  localparam logic [IDX_W-1:0] INIT_IDX = IDX_W'(INIT_SLOT);

  logic [IDX_W-1:0] cnt;
  logic             pend;
  logic             eosTog;
  logic [IDX_W-1:0] nextPtr;
  logic             lastStep;

  always_comb begin
    nextPtr  = (ptr >= endSlot) ? INIT_IDX : ptr + 1'b1;
    lastStep = (cnt == maxCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= INIT_IDX; cnt <= '0; busy <= 1'b0;
      pend <= 1'b0; eosTog <= 1'b0; intPulse <= 1'b0;
    end else if (seqReset) begin
      ptr <= INIT_IDX; cnt <= '0; busy <= 1'b0;
      pend <= 1'b0; eosTog <= 1'b0; intPulse <= 1'b0;
    end else begin
      intPulse <= 1'b0;
      if (stepDone) begin
        if (lastStep) begin
          cnt      <= '0;
          ptr      <= (contRun && !wrapAtEnd) ? INIT_IDX : nextPtr;
          busy     <= contRun || pend || trig;
          pend     <= 1'b0;
          eosTog   <= ~eosTog;
          intPulse <= intEn && (!intAlt || eosTog);
        end else begin
          cnt <= cnt + 1'b1;
          ptr <= nextPtr;
          if (trig) pend <= 1'b1;
          else if (pendClear) pend <= 1'b0;
        end
      end else if (trig) begin
        if (busy) pend <= 1'b1;
        else busy <= 1'b1;
      end else if (pendClear) begin
        pend <= 1'b0;
      end
    end
  end

  assert_pend_implies_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    pend |-> busy);
  assert_reset_to_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqReset |=> (ptr == INIT_IDX && !busy));
  assert_irq_one_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |=> !intPulse);
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [6:0]        cfgData,
  input  logic              trigEvA,
  input  logic              trigEvB,
  input  logic              trigExt,
  input  logic              convDone,
  input  logic [CHAN_W-1:0] lookChan,
  output dpStrobe_t         strobe,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output logic              irqLo,
  output logic              irqHi
);
  logic cascadeR, contRunR, wrapR;
  logic maskA1, maskB1, maskExt1, intEn1, intAlt1;
  logic maskB2, intEn2, intAlt2;
  logic [6:0] cntR;

  logic wrMode, wrLo, wrHi, wrCnt;
  logic [1:0] trigV, clearV, resetV, stepV, busyV, intV, intEnV, intAltV;
  logic [IDX_W-1:0] ptrV [2];
  logic [IDX_W-1:0] endV [2];
  logic [IDX_W-1:0] maxV [2];

  logic waitingR, ownerR, dropR, convStartR;
  logic [IDX_W-1:0] flightSlotR;
  logic [CHAN_W-1:0] convChanR;
  logic wantLo, wantHi;

  always_comb begin
    wrMode = wrEn && wrAddr == 3'd0;
    wrLo   = wrEn && wrAddr == 3'd1;
    wrHi   = wrEn && wrAddr == 3'd2;
    wrCnt  = wrEn && wrAddr == 3'd3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cascadeR <= 1'b0; contRunR <= 1'b0; wrapR <= 1'b0;
      maskA1 <= 1'b0; maskB1 <= 1'b0; maskExt1 <= 1'b0; intEn1 <= 1'b0; intAlt1 <= 1'b0;
      maskB2 <= 1'b0; intEn2 <= 1'b0; intAlt2 <= 1'b0;
      cntR <= '0;
    end else begin
      if (wrMode) {wrapR, contRunR, cascadeR} <= cfgData[2:0];
      if (wrLo) begin
        maskA1 <= cfgData[2]; maskB1 <= cfgData[3]; maskExt1 <= cfgData[4];
        intEn1 <= cfgData[5]; intAlt1 <= cfgData[6];
      end
      if (wrHi) begin
        maskB2 <= cfgData[3]; intEn2 <= cfgData[5]; intAlt2 <= cfgData[6];
      end
      if (wrCnt) cntR <= cfgData;
    end
  end

  always_comb begin
    trigV[0]   = (wrLo && cfgData[0]) || (trigEvA && maskA1) || (trigExt && maskExt1)
               || (cascadeR && trigEvB && maskB1);
    trigV[1]   = !cascadeR && ((wrHi && cfgData[0]) || (trigEvB && maskB2));
    clearV     = {wrHi && !cfgData[0], wrLo && !cfgData[0]};
    resetV     = {wrHi && cfgData[1], wrLo && cfgData[1]};
    intEnV     = {intEn2, intEn1};
    intAltV    = {intAlt2, intAlt1};
    endV[0]    = cascadeR ? IDX_W'(SLOT_N - 1) : IDX_W'(HALF_N - 1);
    endV[1]    = IDX_W'(SLOT_N - 1);
    maxV[0]    = cascadeR ? cntR[3:0] : {1'b0, cntR[2:0]};
    maxV[1]    = {1'b0, cntR[6:4]};
    for (int g = 0; g < 2; g++)
      stepV[g] = waitingR && convDone && !dropR && (int'(ownerR) == g);
  end

  for (genvar g = 0; g < 2; g++) begin : gSeq
    adcseq_track #(.INIT_SLOT(g * HALF_N)) uTrack (
      .clk(clk), .rstN(rstN), .endSlot(endV[g]), .maxCnt(maxV[g]),
      .contRun(contRunR), .wrapAtEnd(wrapR), .trig(trigV[g]),
      .pendClear(clearV[g]), .seqReset(resetV[g]), .stepDone(stepV[g]),
      .intEn(intEnV[g]), .intAlt(intAltV[g]),
      .busy(busyV[g]), .ptr(ptrV[g]), .intPulse(intV[g])
    );
  end

  always_comb begin
    wantLo          = busyV[0];
    wantHi          = busyV[1] && !cascadeR;
    strobe.lookIdx  = wantLo ? ptrV[0] : ptrV[1];
    strobe.resWe    = waitingR && convDone;
    strobe.resIdx   = flightSlotR;
    strobe.slotWe   = wrEn && wrAddr[2];
    strobe.slotWord = wrAddr[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitingR <= 1'b0; ownerR <= 1'b0; dropR <= 1'b0; convStartR <= 1'b0;
      flightSlotR <= '0; convChanR <= '0;
    end else begin
      convStartR <= 1'b0;
      if (!waitingR) begin
        if (wantLo || wantHi) begin
          waitingR    <= 1'b1;
          ownerR      <= !wantLo;
          flightSlotR <= strobe.lookIdx;
          convChanR   <= lookChan;
          convStartR  <= 1'b1;
          dropR       <= wantLo ? resetV[0] : resetV[1];
        end
      end else if (convDone) begin
        waitingR <= 1'b0;
        dropR    <= 1'b0;
      end else if (resetV[ownerR]) begin
        dropR <= 1'b1;
      end
    end
  end

  assign convStart = convStartR;
  assign convChan  = convChanR;
  assign irqLo     = intV[0];
  assign irqHi     = intV[1];

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (waitingR && !convDone) |=> !convStart);
  assert_no_high_when_joined_R3: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && ownerR) |-> !$past(cascadeR));
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdData,
  input  logic              trigEvA,
  input  logic              trigEvB,
  input  logic              trigExt,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convDone,
  input  logic [CONV_W-1:0] convData,
  output logic              irqLo,
  output logic              irqHi
);
  dpStrobe_t         strobe;
  logic [CHAN_W-1:0] lookChan;

  adcseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .cfgData(wrData[6:0]),
    .trigEvA(trigEvA), .trigEvB(trigEvB), .trigExt(trigExt), .convDone(convDone),
    .lookChan(lookChan), .strobe(strobe), .convStart(convStart), .convChan(convChan),
    .irqLo(irqLo), .irqHi(irqHi)
  );

  adcseq_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .convData(convData),
    .rdIdx(rdIdx), .lookChan(lookChan), .rdData(rdData)
  );
endmodule

// File: tb/adc_autoseq_test.sv
module adc_autoseq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0] rdIdx = '0;
  logic [15:0] rdData;
  logic trigEvA = 1'b0, trigEvB = 1'b0, trigExt = 1'b0;
  logic convStart;
  logic [3:0] convChan;
  logic convDone = 1'b0;
  logic [11:0] convData = '0;
  logic irqLo, irqHi;

  always #2 clk = ~clk;

  adc_autoseq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .trigEvA(trigEvA), .trigEvB(trigEvB),
    .trigExt(trigExt), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .convData(convData), .irqLo(irqLo), .irqHi(irqHi)
  );

  // slot -> channel stimulus; expected result derived per entry
  localparam logic [3:0] CHAN_TAB [16] = '{4'd3, 4'd8, 4'd13, 4'd2, 4'd7, 4'd12, 4'd1, 4'd6,
                                           4'd11, 4'd0, 4'd5, 4'd10, 4'd15, 4'd4, 4'd9, 4'd14};

  function automatic logic [11:0] sampleOf(logic [3:0] ch);
    return {ch, ~ch, ch};
  endfunction
  function automatic logic [15:0] expRes(logic [3:0] ch);
    return {sampleOf(ch), 4'b0000};
  endfunction

  // converter model
  int nConv = 0;
  int lat = 0;
  int irqLoCnt = 0;
  int irqHiCnt = 0;
  logic [3:0] curChan = '0;
  logic [3:0] chanLog [256];

  always @(posedge clk) begin
    convDone <= 1'b0;
    if (!rstN) begin
      nConv <= 0; lat <= 0;
    end else begin
      if (irqLo) irqLoCnt <= irqLoCnt + 1;
      if (irqHi) irqHiCnt <= irqHiCnt + 1;
      if (convStart) begin
        if (nConv < 256) chanLog[nConv] <= convChan;
        curChan <= convChan;
        nConv <= nConv + 1;
        lat <= 3;
      end else if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          convDone <= 1'b1;
          convData <= sampleOf(curChan);
        end
      end
    end
  end

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulse(logic a, logic b, logic e);
    @(negedge clk); trigEvA = a; trigEvB = b; trigExt = e;
    @(negedge clk); trigEvA = 1'b0; trigEvB = 1'b0; trigExt = 1'b0;
  endtask

  task automatic waitFor(int n);
    int t = 0;
    while (nConv < n && t < 3000) begin @(posedge clk); t++; end
    repeat (15) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readRes(int i, output logic [15:0] v);
    @(negedge clk); rdIdx = 4'(i); #1 v = rdData;
  endtask

  initial begin
    logic [15:0] v;
    int base;
    int n1;
    repeat (3) @(negedge clk);
    // R12 reset state
    readRes(0, v);
    check("R12 result zero", v, 16'h0);
    check("R12 outputs low", {13'b0, convStart, irqLo, irqHi}, 16'h0);
    rstN = 1'b1;
    idle(2);

    // R1 R2 R3: joined mode walk of the whole table
    for (int k = 0; k < 4; k++)
      wr(3'(4 + k), {CHAN_TAB[4*k+3], CHAN_TAB[4*k+2], CHAN_TAB[4*k+1], CHAN_TAB[4*k]});
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'h000F);
    wr(3'd1, 16'h0021);
    waitFor(16);
    for (int i = 0; i < 16; i++) begin
      readRes(i, v);
      check("R1 R2 slot result", v, expRes(CHAN_TAB[i]));
    end
    check("R3 joined count", 16'(nConv), 16'd16);
    check("R11 one irq per session", 16'(irqLoCnt), 16'd1);

    // R4 start/stop resume, split mode
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0002);
    base = nConv;
    wr(3'd1, 16'h0001);
    waitFor(base + 3);
    check("R3 split count", 16'(nConv - base), 16'd3);
    check("R1 first session chans", {4'b0, chanLog[base], chanLog[base+1], chanLog[base+2]},
          {4'b0, CHAN_TAB[0], CHAN_TAB[1], CHAN_TAB[2]});
    wr(3'd4, 16'h5555);
    wr(3'd5, 16'hAAAA);
    wr(3'd1, 16'h0004);
    pulse(1, 0, 0);
    waitFor(base + 6);
    readRes(3, v); check("R4 resume slot3", v, expRes(4'h5));
    readRes(5, v); check("R4 resume slot5", v, expRes(4'hA));
    readRes(6, v); check("R4 slot6 untouched", v, expRes(CHAN_TAB[6]));
    pulse(1, 0, 0);
    waitFor(base + 9);
    check("R3 low wraps 7 to 0", {12'b0, chanLog[base+8]}, 16'h5);
    readRes(0, v); check("R4 wrap result0", v, expRes(4'h5));

    // R7 masks and mode gating (pointer now at slot 1)
    base = nConv;
    pulse(0, 0, 1);
    idle(15);
    check("R7 ext masked", 16'(nConv - base), 16'd0);
    wr(3'd1, 16'h001C);
    pulse(0, 1, 0);
    idle(15);
    check("R7 evB ignored for low in split", 16'(nConv - base), 16'd0);
    pulse(0, 0, 1);
    waitFor(base + 3);
    check("R7 ext enabled", 16'(nConv - base), 16'd3);
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h001E);
    base = nConv;
    pulse(0, 1, 0);
    waitFor(base + 1);
    check("R7 evB starts low in joined", {11'(nConv - base), chanLog[base], 1'b0}, {11'd1, 4'h5, 1'b0});

    // R3 R7 high sequencer
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0010);
    wr(3'd2, 16'h0002);
    base = nConv;
    wr(3'd2, 16'h0001);
    waitFor(base + 2);
    check("R3 high slots 8 9", {8'(nConv - base), chanLog[base], chanLog[base+1]},
          {8'd2, CHAN_TAB[8], CHAN_TAB[9]});
    wr(3'd0, 16'h0001);
    base = nConv;
    wr(3'd2, 16'h0001);
    idle(15);
    check("R7 high start ignored when joined", 16'(nConv - base), 16'd0);
    wr(3'd0, 16'h0000);

    // R10 priority
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0006);
    wr(3'd2, 16'h000A);
    base = nConv;
    pulse(1, 1, 0);
    waitFor(base + 2);
    check("R10 low first then high", {8'(nConv - base), chanLog[base], chanLog[base+1]},
          {8'd2, 4'h5, CHAN_TAB[8]});

    // R6 reset mid-table
    wr(3'd3, 16'h0002);
    base = nConv;
    pulse(1, 0, 0);
    waitFor(base + 3);
    wr(3'd1, 16'h0006);
    base = nConv;
    pulse(1, 0, 0);
    waitFor(base + 3);
    check("R6 restarts at slot0", {chanLog[base], chanLog[base+1], chanLog[base+2], chanLog[base+3]},
          {4'h5, 4'h5, 4'h5, 4'h0} | {12'b0, chanLog[base+3]});

    // R9 one pending, extras lost
    wr(3'd1, 16'h0006);
    base = nConv;
    pulse(1, 0, 0); idle(2);
    pulse(1, 0, 0); idle(2);
    pulse(1, 0, 0);
    waitFor(base + 6);
    idle(20);
    check("R9 two sessions", 16'(nConv - base), 16'd6);
    // R8 cancel pending
    wr(3'd1, 16'h0006);
    base = nConv;
    pulse(1, 0, 0); idle(2);
    pulse(1, 0, 0);
    wr(3'd1, 16'h0004);
    waitFor(base + 3);
    idle(20);
    check("R8 pending cancelled", 16'(nConv - base), 16'd3);

    // R5 continuous operation
    wr(3'd4, 16'h3210);
    wr(3'd5, 16'h7654);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'h0001);
    base = nConv;
    wr(3'd1, 16'h0001);
    waitFor(base + 5);
    check("R5 wrap at count", {chanLog[base], chanLog[base+1], chanLog[base+2], chanLog[base+3]},
          16'h0101);
    wr(3'd1, 16'h0002);
    wr(3'd0, 16'h0006);
    wr(3'd1, 16'h0002);
    base = nConv;
    wr(3'd1, 16'h0001);
    waitFor(base + 9);
    for (int k = 0; k < 9; k++)
      check("R5 wrap at last slot", {12'b0, chanLog[base+k]}, 16'(k % 8));
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0002);
    idle(30);
    n1 = nConv;
    idle(30);
    check("R6 reset stops continuous", 16'(nConv), 16'(n1));

    // R11 every other session
    wr(3'd1, 16'h0066);
    wr(3'd3, 16'h0000);
    n1 = irqLoCnt;
    for (int k = 0; k < 4; k++) begin
      pulse(1, 0, 0);
      idle(20);
    end
    check("R11 every other irq", 16'(irqLoCnt - n1), 16'd2);
    check("R11 high irq disabled", 16'(irqHiCnt), 16'd0);

    finishRun();
  end
endmodule